// File: doc/BRIEF.md
# SPI Buffer Level and Word-Count Manager

This block manages one byte-counted word buffer that several SPI channels may claim. Exactly one channel may own it at a time: each channel raises a receive-side and/or a transmit-side claim, and if claims come from more than one channel, nobody gets the buffer. The owner's claims set the direction. In transmit the host side writes words and the shift engine pops them. In receive the shift engine pushes words and the host side reads them.

Fill and thresholds are measured in bytes. Each stored word costs 1, 2 or 4 bytes, chosen by the programmed word length. Two threshold events pace the host side: transmit-almost-empty and receive-almost-full. Each fires once and re-arms only after the host has moved the programmed number of bytes. A word counter counts transfers made by the shift engine. When it reaches a programmed total, it raises an end-of-count event and halts the engine side. The events are sticky status bits that are cleared by write-one strobes.

Top module: `spibuf_level_mgr`

## Requirements
- R1: `grant` becomes one-hot for the only channel with any claim (`ch_rx_en | ch_tx_en`) one cycle after the claims are sampled. It is all zero when no channel or more than one channel has a claim.
- R2: One cycle after the claims are sampled, `tx_mode` is high if the owning channel has its transmit claim set. `rx_mode` is high if the owner has only its receive claim set. Both are low when nothing is owned. Transmit wins when the owner sets both claims.
- R3: A word costs 1 byte for word lengths up to 8 bits, 2 bytes for 9 to 16 bits and 4 bytes for 17 to 32 bits. `fill_bytes` equals the stored words times that cost. The buffer holds at most 64 bytes.
- R4: Words leave in the order they entered. `rd_data` carries the popped word in the cycle after an accepted pop (`eng_pop` in transmit, `host_rd` in receive).
- R5: A push that would exceed 64 bytes, or a pop from an empty buffer, changes nothing in the buffer and sets error status bit 3.
- R6: Status bit 0 (transmit-almost-empty) sets when, in transmit, the free bytes are at least `cfg_ael` while the event is armed. After it fires, the event re-arms only once `cfg_ael` bytes have been written.
- R7: Status bit 1 (receive-almost-full) sets when, in receive, the fill equals `cfg_afl` bytes while the event is armed. After it fires, the event re-arms only once `cfg_afl` bytes have been read.
- R8: The word counter counts accepted engine-side transfers. When the count reaches a non-zero `cfg_wcnt`, status bit 2 and `xfer_halt` set. While halted, engine strobes are ignored. Clearing bit 2 drops the halt and restarts the count from zero. When `cfg_wcnt` is 0 there is no counting and no event.
- R9: Status bits stay set until a `evt_clr` strobe hits them. A bit that is set again in the same cycle as its clear stays set.
- R10: In any cycle where neither mode is active, the buffer is emptied, both threshold events re-arm and the word count and halt reset.
- R11: After reset, `grant`, `tx_mode`, `rx_mode`, `fill_bytes`, `xfer_halt` and `evt_status` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_rx_en | input | NUM_CH | Per-channel receive-side claim |
| ch_tx_en | input | NUM_CH | Per-channel transmit-side claim |
| cfg_wlen | input | 6 | SPI word length in bits (4 to 32) |
| cfg_ael | input | clog2(DEPTH_BYTES+1) | Transmit-almost-empty level in bytes |
| cfg_afl | input | clog2(DEPTH_BYTES+1) | Receive-almost-full level in bytes |
| cfg_wcnt | input | WCNT_W | Word total for the end-of-count event, 0 disables it |
| host_wr | input | 1 | Host-side word write strobe (transmit) |
| host_wdata | input | DATA_W | Host-side write word |
| host_rd | input | 1 | Host-side word read strobe (receive) |
| eng_push | input | 1 | Shift-engine received-word strobe |
| eng_wdata | input | DATA_W | Shift-engine received word |
| eng_pop | input | 1 | Shift-engine word fetch strobe (transmit) |
| evt_clr | input | 4 | Write-one-to-clear strobes for the status bits |
| rd_data | output | DATA_W | Word from the last accepted pop |
| grant | output | NUM_CH | One-hot buffer owner |
| tx_mode | output | 1 | Buffer serves transmit |
| rx_mode | output | 1 | Buffer serves receive |
| fill_bytes | output | clog2(DEPTH_BYTES+1) | Stored bytes |
| xfer_halt | output | 1 | Word total reached, engine side halted |
| evt_status | output | 4 | Sticky events: 0 tx-almost-empty, 1 rx-almost-full, 2 end-of-count, 3 error |

## Verification
Some properties hold on every cycle, and the assertions check those:
- the owner stays one-hot and the two modes never overlap;
- the fill never passes 64 bytes;
- an overfull transmit write always flags an error;
- status bits never drop without a clear;
- a halt always comes with its end-of-count bit;
- a cycle without a mode always leaves the buffer empty.

Other behaviour depends on history, so only the bench's scenarios, compared against a queue model, can show it:
- data order;
- the byte cost at each word length;
- the exact cycle when a threshold event fires and re-arms after the right number of bytes;
- the word total and its restart.

// File: rtl/spibuf_pkg.sv
package spibuf_pkg;
  localparam int EV_TXAE = 0;
  localparam int EV_RXAF = 1;
  localparam int EV_EOC  = 2;
  localparam int EV_ERR  = 3;
  localparam int EV_N    = 4;

  // bytes one stored word occupies for a given SPI word length in bits
  function automatic logic [2:0] bytes_per_word(input logic [5:0] wlen);
    if (wlen <= 6'd8)       return 3'd1;
    else if (wlen <= 6'd16) return 3'd2;
    else                    return 3'd4;
  endfunction
endpackage

// File: rtl/spibuf_owner_arb.sv
module spibuf_owner_arb #(
  parameter int NUM_CH = 4
)(
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] rx_en,
  input  logic [NUM_CH-1:0] tx_en,
  output logic [NUM_CH-1:0] grant,
  output logic              tx_mode,
  output logic              rx_mode
);
  logic [NUM_CH-1:0] req;
  logic              sole;

  always_comb begin
    req  = rx_en | tx_en;
    sole = (req != '0) && ((req & (req - 1'b1)) == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant   <= '0;
      tx_mode <= 1'b0;
      rx_mode <= 1'b0;
    end else begin
      grant   <= sole ? req : '0;
      tx_mode <= sole && ((req & tx_en) != '0);
      rx_mode <= sole && ((req & tx_en) == '0);
    end
  end
endmodule

// File: rtl/spibuf_word_store.sv
module spibuf_word_store #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 7
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rdata,
  output logic [CNT_W-1:0]  entries
);
  localparam int AW = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr, rptr;

  // storage and read register without reset so a block RAM can hold them
  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= wdata;
    if (rd_en) rdata     <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr    <= '0;
      rptr    <= '0;
      entries <= '0;
    end else begin
      if (wr_en) wptr <= wptr + 1'b1;
      if (rd_en) rptr <= rptr + 1'b1;
      entries <= entries + CNT_W'(wr_en) - CNT_W'(rd_en);
    end
  end
endmodule

// File: rtl/spibuf_level_event.sv
module spibuf_level_event #(
  parameter int LVL_W = 7
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             active,
  input  logic             hit,
  input  logic             step,
  input  logic [2:0]       step_bytes,
  input  logic [LVL_W-1:0] level,
  output logic             fire
);
  logic             armed;
  logic [LVL_W:0]   moved;
  logic [LVL_W+1:0] moved_next;

  always_comb begin
    moved_next = {1'b0, moved} + (step ? (LVL_W+2)'(step_bytes) : '0);
    fire       = active && armed && hit;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      armed <= 1'b1;
      moved <= '0;
    end else if (fire) begin
      armed <= 1'b0;
      moved <= step ? (LVL_W+1)'(step_bytes) : '0;
    end else if (!armed) begin
      moved <= moved_next[LVL_W:0];
      if (moved_next >= (LVL_W+2)'(level)) armed <= 1'b1;
    end
  end
endmodule

// File: rtl/spibuf_word_counter.sv
module spibuf_word_counter #(
  parameter int WCNT_W = 16
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic [WCNT_W-1:0] target,
  input  logic              step,
  input  logic              clr,
  output logic              done,
  output logic              halt
);
  logic [WCNT_W-1:0] count;
  logic              enabled;

  always_comb begin
    enabled = (target != '0);
    done    = step && enabled && !halt && ((count + 1'b1) == target);
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      count <= '0;
      halt  <= 1'b0;
    end else if (done) begin
      count <= count + 1'b1;
      halt  <= 1'b1;
    end else if (clr) begin
      count <= '0;
      halt  <= 1'b0;
    end else if (step && enabled && !halt) begin
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/spibuf_level_mgr.sv
module spibuf_level_mgr import spibuf_pkg::*; #(
  parameter int NUM_CH      = 4,
  parameter int DEPTH_BYTES = 64,
  parameter int DATA_W      = 32,
  parameter int WCNT_W      = 16
)(
  input  logic                               clk,
  input  logic                               rst,
  input  logic [NUM_CH-1:0]                  ch_rx_en,
  input  logic [NUM_CH-1:0]                  ch_tx_en,
  input  logic [5:0]                         cfg_wlen,
  input  logic [$clog2(DEPTH_BYTES+1)-1:0]   cfg_ael,
  input  logic [$clog2(DEPTH_BYTES+1)-1:0]   cfg_afl,
  input  logic [WCNT_W-1:0]                  cfg_wcnt,
  input  logic                               host_wr,
  input  logic [DATA_W-1:0]                  host_wdata,
  input  logic                               host_rd,
  input  logic                               eng_push,
  input  logic [DATA_W-1:0]                  eng_wdata,
  input  logic                               eng_pop,
  input  logic [EV_N-1:0]                    evt_clr,
  output logic [DATA_W-1:0]                  rd_data,
  output logic [NUM_CH-1:0]                  grant,
  output logic                               tx_mode,
  output logic                               rx_mode,
  output logic [$clog2(DEPTH_BYTES+1)-1:0]   fill_bytes,
  output logic                               xfer_halt,
  output logic [EV_N-1:0]                    evt_status
);
  localparam int LVL_W = $clog2(DEPTH_BYTES+1);

  logic [2:0]        bpw;
  int                cap_words;
  logic [LVL_W-1:0]  entries;
  logic              flush, prod_req, cons_req, room, wr_ok, rd_ok;
  logic              word_step, tx_fire, rx_fire, eoc_fire, access_err;
  logic              tx_hit, rx_hit;
  logic [DATA_W-1:0] wdata;
  logic [EV_N-1:0]   ev_set;

  spibuf_owner_arb #(.NUM_CH(NUM_CH)) u_arb (
    .clk(clk), .rst(rst), .rx_en(ch_rx_en), .tx_en(ch_tx_en),
    .grant(grant), .tx_mode(tx_mode), .rx_mode(rx_mode)
  );

  always_comb begin
    bpw = bytes_per_word(cfg_wlen);
    case (bpw)
      3'd1:    cap_words = DEPTH_BYTES;
      3'd2:    cap_words = DEPTH_BYTES / 2;
      default: cap_words = DEPTH_BYTES / 4;
    endcase
    fill_bytes = LVL_W'(int'(entries) * int'(bpw));
    flush      = !(tx_mode || rx_mode);
    prod_req   = tx_mode ? host_wr : (rx_mode && eng_push && !xfer_halt);
    cons_req   = tx_mode ? (eng_pop && !xfer_halt) : (rx_mode && host_rd);
    room       = int'(entries) < cap_words;
    wr_ok      = prod_req && room;
    rd_ok      = cons_req && (entries != '0);
    access_err = (prod_req && !room) || (cons_req && (entries == '0));
    wdata      = tx_mode ? host_wdata : eng_wdata;
    word_step  = tx_mode ? rd_ok : (rx_mode && wr_ok);
    tx_hit     = (DEPTH_BYTES - int'(fill_bytes)) >= int'(cfg_ael);
    rx_hit     = (fill_bytes == cfg_afl);
  end

  spibuf_word_store #(.DEPTH(DEPTH_BYTES), .DATA_W(DATA_W), .CNT_W(LVL_W)) u_store (
    .clk(clk), .rst(rst), .flush(flush), .wr_en(wr_ok), .wdata(wdata),
    .rd_en(rd_ok), .rdata(rd_data), .entries(entries)
  );

  spibuf_level_event #(.LVL_W(LVL_W)) u_tx_level (
    .clk(clk), .rst(rst), .flush(flush), .active(tx_mode), .hit(tx_hit),
    .step(tx_mode && wr_ok), .step_bytes(bpw), .level(cfg_ael), .fire(tx_fire)
  );

  spibuf_level_event #(.LVL_W(LVL_W)) u_rx_level (
    .clk(clk), .rst(rst), .flush(flush), .active(rx_mode), .hit(rx_hit),
    .step(rx_mode && rd_ok), .step_bytes(bpw), .level(cfg_afl), .fire(rx_fire)
  );

  spibuf_word_counter #(.WCNT_W(WCNT_W)) u_wcount (
    .clk(clk), .rst(rst), .flush(flush), .target(cfg_wcnt), .step(word_step),
    .clr(evt_clr[EV_EOC]), .done(eoc_fire), .halt(xfer_halt)
  );

  always_comb begin
    ev_set          = '0;
    ev_set[EV_TXAE] = tx_fire;
    ev_set[EV_RXAF] = rx_fire;
    ev_set[EV_EOC]  = eoc_fire;
    ev_set[EV_ERR]  = access_err;
  end

  always_ff @(posedge clk) begin
    if (rst) evt_status <= '0;
    else     evt_status <= (evt_status & ~evt_clr) | ev_set;
  end
endmodule

// File: rtl/spibuf_level_mgr_chk.sv
module spibuf_level_mgr_chk import spibuf_pkg::*; #(
  parameter int NUM_CH      = 4,
  parameter int DEPTH_BYTES = 64
)(
  input logic                             clk,
  input logic                             rst,
  input logic [NUM_CH-1:0]                grant,
  input logic                             tx_mode,
  input logic                             rx_mode,
  input logic [$clog2(DEPTH_BYTES+1)-1:0] fill_bytes,
  input logic                             host_wr,
  input logic [5:0]                       cfg_wlen,
  input logic [EV_N-1:0]                  evt_clr,
  input logic [EV_N-1:0]                  evt_status,
  input logic                             xfer_halt
);
  assert_grant_onehot_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  assert_mode_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
    (tx_mode || rx_mode) |-> (!(tx_mode && rx_mode) && grant != '0));

  assert_fill_bound_R3: assert property (@(posedge clk) disable iff (rst)
    int'(fill_bytes) <= DEPTH_BYTES);

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    (tx_mode && host_wr && (int'(fill_bytes) + int'(bytes_per_word(cfg_wlen)) > DEPTH_BYTES))
    |=> evt_status[EV_ERR]);

  assert_halt_flagged_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(xfer_halt) |-> evt_status[EV_EOC]);

  assert_status_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (|(evt_status & ~evt_clr)) |=>
      ((evt_status & $past(evt_status & ~evt_clr)) == $past(evt_status & ~evt_clr)));

  assert_release_empty_R10: assert property (@(posedge clk) disable iff (rst)
    !(tx_mode || rx_mode) |=> (fill_bytes == '0));
endmodule

bind spibuf_level_mgr spibuf_level_mgr_chk #(
  .NUM_CH(NUM_CH), .DEPTH_BYTES(DEPTH_BYTES)
) i_chk (.*);

// File: tb/test_spibuf_level_mgr.sv
module test_spibuf_level_mgr;
  localparam int CLK_PERIOD = 10;
  localparam int NCH   = 4;
  localparam int DEPTH = 64;
  localparam int DW    = 32;
  localparam int WW    = 16;
  localparam int LW    = $clog2(DEPTH+1);
  localparam int WATCHDOG_CYCLES = 50000;

  logic clk = 1'b0;
  logic rst;
  logic [NCH-1:0] ch_rx_en, ch_tx_en;
  logic [5:0]     cfg_wlen;
  logic [LW-1:0]  cfg_ael, cfg_afl;
  logic [WW-1:0]  cfg_wcnt;
  logic           host_wr, host_rd, eng_push, eng_pop;
  logic [DW-1:0]  host_wdata, eng_wdata, rd_data;
  logic [3:0]     evt_clr, evt_status;
  logic [NCH-1:0] grant;
  logic           tx_mode, rx_mode, xfer_halt;
  logic [LW-1:0]  fill_bytes;

  spibuf_level_mgr #(.NUM_CH(NCH), .DEPTH_BYTES(DEPTH), .DATA_W(DW), .WCNT_W(WW)) i_spibuf_level_mgr (
    .clk(clk), .rst(rst), .ch_rx_en(ch_rx_en), .ch_tx_en(ch_tx_en), .cfg_wlen(cfg_wlen),
    .cfg_ael(cfg_ael), .cfg_afl(cfg_afl), .cfg_wcnt(cfg_wcnt), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rd(host_rd), .eng_push(eng_push), .eng_wdata(eng_wdata),
    .eng_pop(eng_pop), .evt_clr(evt_clr), .rd_data(rd_data), .grant(grant),
    .tx_mode(tx_mode), .rx_mode(rx_mode), .fill_bytes(fill_bytes), .xfer_halt(xfer_halt),
    .evt_status(evt_status)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference state
  logic [DW-1:0]  q[$];
  logic [NCH-1:0] m_grant;
  bit             m_tx, m_rx, m_halt, tx_arm, rx_arm, rd_chk;
  logic [3:0]     m_stat;
  int             tx_cnt, rx_cnt, wc;
  logic [DW-1:0]  m_rdat;
  int             vectors = 0;
  int             miscompares = 0;
  bit             done = 0;

  function automatic int bpw_of(input int wl);
    if (wl <= 8) return 1;
    if (wl <= 16) return 2;
    return 4;
  endfunction

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    q.delete();
    m_grant = '0; m_tx = 0; m_rx = 0; m_halt = 0; m_stat = '0;
    tx_arm = 1; rx_arm = 1; tx_cnt = 0; rx_cnt = 0; wc = 0; rd_chk = 0;
  endtask

  task automatic upd_arm(input bit fl, input bit fire, input bit st, input int b, input int lvl,
                         inout bit arm, inout int cnt);
    if (fl) begin arm = 1; cnt = 0; end
    else if (fire) begin arm = 0; cnt = st ? b : 0; end
    else if (!arm) begin
      cnt += st ? b : 0;
      if (cnt >= lvl) arm = 1;
    end
  endtask

  task automatic model_step();
    int b = bpw_of(int'(cfg_wlen));
    int fill = q.size() * b;
    bit flush = !(m_tx || m_rx);
    bit prod, cons, wr_ok, rd_ok, err, txf, rxf, wstep, wcf;
    logic [NCH-1:0] req = ch_rx_en | ch_tx_en;
    prod  = m_tx ? host_wr : (m_rx && eng_push && !m_halt);
    cons  = m_tx ? (eng_pop && !m_halt) : (m_rx && host_rd);
    wr_ok = prod && (fill + b <= DEPTH);
    rd_ok = cons && (q.size() > 0);
    err   = (prod && !wr_ok) || (cons && !rd_ok);
    txf   = m_tx && tx_arm && (DEPTH - fill >= int'(cfg_ael));
    rxf   = m_rx && rx_arm && (fill == int'(cfg_afl));
    wstep = m_tx ? rd_ok : (m_rx && wr_ok);
    wcf   = wstep && cfg_wcnt != 0 && !m_halt && (wc + 1 == int'(cfg_wcnt));
    rd_chk = rd_ok;
    if (rd_ok) m_rdat = q.pop_front();
    if (wr_ok) q.push_back(m_tx ? host_wdata : eng_wdata);
    if (flush) q.delete();
    upd_arm(flush, txf, m_tx && wr_ok, b, int'(cfg_ael), tx_arm, tx_cnt);
    upd_arm(flush, rxf, m_rx && rd_ok, b, int'(cfg_afl), rx_arm, rx_cnt);
    if (flush) begin wc = 0; m_halt = 0; end
    else if (wcf) begin wc++; m_halt = 1; end
    else if (evt_clr[2]) begin wc = 0; m_halt = 0; end
    else if (wstep && cfg_wcnt != 0) wc++;
    m_stat = (m_stat & ~evt_clr) | {err, wcf, rxf, txf};
    if ($countones(req) == 1) begin
      m_grant = req;
      m_tx = (req & ch_tx_en) != '0;
      m_rx = !m_tx;
    end else begin
      m_grant = '0; m_tx = 0; m_rx = 0;
    end
  endtask

  task automatic compare_all();
    chk("R1 grant", grant, m_grant);
    chk("R2 tx_mode", tx_mode, m_tx);
    chk("R2 rx_mode", rx_mode, m_rx);
    chk("R3 fill_bytes", fill_bytes, q.size() * bpw_of(int'(cfg_wlen)));
    chk("R6 tx almost-empty bit", evt_status[0], m_stat[0]);
    chk("R7 rx almost-full bit", evt_status[1], m_stat[1]);
    chk("R8 end-of-count bit", evt_status[2], m_stat[2]);
    chk("R8 halt", xfer_halt, m_halt);
    chk("R5 error bit", evt_status[3], m_stat[3]);
    if (rd_chk) chk("R4 rd_data order", rd_data, m_rdat);
  endtask

  task automatic tick();
    if (rst) model_reset(); else model_step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    host_wr = 0; host_rd = 0; eng_push = 0; eng_pop = 0; evt_clr = '0;
  endtask

  task automatic release_buf();
    ch_rx_en = '0; ch_tx_en = '0;
    tick(); tick();
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end

  initial begin
    int f0;
    rst = 1; ch_rx_en = '0; ch_tx_en = '0; cfg_wlen = 6'd8; cfg_ael = 7'd16; cfg_afl = '0;
    cfg_wcnt = '0; host_wr = 0; host_rd = 0; eng_push = 0; eng_pop = 0;
    host_wdata = '0; eng_wdata = '0; evt_clr = '0;
    @(negedge clk);
    tick(); tick(); tick();
    rst = 0;
    tick();
    chk("R11 reset status", evt_status, 0);
    chk("R11 reset fill", fill_bytes, 0);
    chk("R11 reset grant", grant, 0);
    chk("R11 reset halt", xfer_halt, 0);

    // ownership and conflict
    ch_tx_en = 4'b0010; tick();
    chk("R1 sole owner", grant, 4'b0010);
    chk("R2 transmit mode", tx_mode, 1);
    ch_rx_en = 4'b0100; tick();
    chk("R1 conflict no owner", grant, 0);
    ch_rx_en = '0; tick();

    // transmit, 1-byte words: fill to capacity, overflow
    for (int i = 0; i < 64; i++) begin host_wr = 1; host_wdata = 32'hA000 + i; tick(); end
    chk("R3 64 one-byte words", fill_bytes, 64);
    host_wr = 1; host_wdata = 32'hDEAD; tick();
    chk("R5 overflow flagged", evt_status[3], 1);
    chk("R5 overflow ignored", fill_bytes, 64);
    evt_clr = 4'b1000; host_wr = 1; tick();
    chk("R9 set beats clear", evt_status[3], 1);
    evt_clr = 4'hF; tick();
    chk("R9 cleared", evt_status, 0);
    for (int i = 0; i < 20; i++) begin eng_pop = 1; tick(); end
    tick();
    release_buf();
    chk("R10 release empties", fill_bytes, 0);

    // transmit, 2-byte words
    cfg_wlen = 6'd12; ch_tx_en = 4'b0001; tick();
    evt_clr = 4'hF; tick();
    for (int i = 0; i < 33; i++) begin host_wr = 1; host_wdata = 32'hB000 + i; tick(); end
    chk("R3 32 two-byte words", fill_bytes, 64);
    chk("R5 overflow at 33rd", evt_status[3], 1);
    release_buf();

    // receive, 4-byte words
    cfg_wlen = 6'd32; cfg_afl = 7'd8; ch_rx_en = 4'b1000; tick();
    evt_clr = 4'hF; tick();
    eng_push = 1; eng_wdata = 32'h1111_2222; tick();
    eng_push = 1; eng_wdata = 32'h3333_4444; tick();
    tick();
    chk("R7 almost-full at 8 bytes", evt_status[1], 1);
    host_rd = 1; tick();
    host_rd = 1; tick();
    evt_clr = 4'hF; tick();
    host_rd = 1; tick();
    chk("R5 underflow flagged", evt_status[3], 1);

    // word total
    cfg_wcnt = 16'd3; evt_clr = 4'hF; tick();
    for (int i = 0; i < 3; i++) begin eng_push = 1; eng_wdata = 32'hC0 + i; tick(); end
    chk("R8 halt at total", xfer_halt, 1);
    f0 = int'(fill_bytes);
    eng_push = 1; tick();
    chk("R8 push ignored while halted", fill_bytes, f0);
    evt_clr = 4'b0100; tick();
    chk("R8 clear releases halt", xfer_halt, 0);
    release_buf();

    // randomized rounds
    for (int r = 0; r < 16; r++) begin
      int own = $urandom_range(0, NCH-1);
      int kind = $urandom_range(0, 3);
      cfg_wlen = 6'($urandom_range(4, 32));
      cfg_ael  = 7'($urandom_range(0, 64));
      cfg_afl  = 7'($urandom_range(0, 64));
      cfg_wcnt = ($urandom_range(0, 2) == 0) ? '0 : 16'($urandom_range(1, 30));
      ch_tx_en = (kind == 0 || kind == 2) ? (4'b1 << own) : '0;
      ch_rx_en = (kind == 1 || kind == 2) ? (4'b1 << own) : '0;
      if (kind == 3) ch_tx_en = (4'b1 << own) | (4'b1 << ((own + 1) % NCH));
      tick();
      for (int c = 0; c < 150; c++) begin
        host_wr = $urandom_range(0, 1); host_rd = $urandom_range(0, 1);
        eng_push = $urandom_range(0, 1); eng_pop = $urandom_range(0, 2) == 0;
        host_wdata = $urandom; eng_wdata = $urandom;
        evt_clr = ($urandom_range(0, 7) == 0) ? 4'($urandom_range(0, 15)) : '0;
        tick();
      end
      release_buf();
    end

    done = 1;
    report();
    $finish;
  end
endmodule